// File: doc/BRIEF.md
# Serial Bit-Clock and Frame-Pulse Generator

This block derives a serial bit clock and a periodic, active-high frame pulse from a fast input clock. The transmit and receive halves of a synchronous serial port use them when they are not fed from outside. A divide value sets the bit-clock period. A period value and a width value shape the frame pulse, counted in bit-clock cycles. Each output comes with a one-cycle strobe that marks its rising edge, so logic in the input-clock domain can act on those edges without detecting them itself.

Two resets act differently. While the device reset is held, the bit clock keeps toggling at half the input clock and the frame pulse stays low. When software clears the generator enable, both outputs go low and stay low. A separate frame enable starts and stops the frame counter. The first frame pulse appears only after a programmed number of bit-clock cycles has passed since that enable.

Top module: `ckfs_gen`

## Requirements
- R1: While `dev_rst` is 1, `clkg` inverts on every input clock edge, `clkg_rise` is 1 exactly in the cycles where `clkg` is 1, and `fsg` and `fsg_rise` are 0.
- R2: While `dev_rst` is 0 and `gen_en` is 0, `clkg`, `clkg_rise`, `fsg` and `fsg_rise` are all 0 from the next clock edge on.
- R3: With `gen_en` = 1 and a latched divide value N ≥ 1, `clkg` has a period of N+1 input clocks. It is high for the first floor((N+1)/2) cycles of each period, and `clkg_rise` is 1 in the first cycle of each period.
- R4: With a latched divide value N = 0, `clkg` follows the input clock and `clkg_rise` is 1 in every cycle.
- R5: Count the clock edge that first samples `frm_en` = 1 (with `gen_en` = 1) as the arming edge. The first `fsg` rise then comes at the (P+1)-th `clkg_rise` after the arming edge, where P = `frm_per`, and in the same cycle as that strobe.
- R6: After that rise, `fsg` stays high for W+1 bit-clock periods (W = `frm_wid`, W < P). It then rises again every P+1 bit-clock periods.
- R7: After `frm_en` is sampled 0, `fsg` is 0 from the next edge on. Setting `frm_en` again restarts the count of R5 from zero.
- R8: A new `div_val` is taken only at the start of a bit-clock period. The period in progress keeps its old length.
- R9: When `gen_en` is first sampled 1 with `dev_rst` = 0, `clkg` and `clkg_rise` are 1 in the next cycle, and a new period starts there using the current `div_val`.
- R10: `fsg_rise` is 1 in exactly the cycles where `fsg` goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that is divided |
| dev_rst | input | 1 | Device-level reset, active high |
| gen_en | input | 1 | Generator enable; 0 holds the generator in software reset |
| frm_en | input | 1 | Frame generator enable |
| div_val | input | DIV_W | Divide value N; bit-clock period is N+1 input clocks |
| frm_per | input | FRM_W | Frame period P; one pulse every P+1 bit clocks |
| frm_wid | input | FRM_W | Frame width W; pulse lasts W+1 bit clocks |
| clkg | output | 1 | Generated bit clock |
| clkg_rise | output | 1 | One-cycle strobe on each bit-clock rise |
| fsg | output | 1 | Frame pulse, active high |
| fsg_rise | output | 1 | One-cycle strobe on each frame-pulse rise |

## Verification
The assertions assume that `frm_per` and `frm_wid` hold still while `frm_en` is 1, that `frm_wid` is below `frm_per`, and that `dev_rst` is high at the first clock edge. The stimulus changes frame settings only after it has cleared `frm_en` and before it sets it again. It starts every run in device reset. It changes `div_val` freely while the generator runs, including in mid-period, because the design is meant to absorb that.

// File: rtl/ckfs_pkg.sv
package ckfs_pkg;
    typedef enum logic [1:0] {
        MODE_DEVRST = 2'd0,
        MODE_IDLE   = 2'd1,
        MODE_RUN    = 2'd2
    } ckfs_mode_e;
endpackage

// File: rtl/ckfs_divider.sv
module ckfs_divider
    import ckfs_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  ckfs_mode_e       mode,
    input  logic [DIV_W-1:0] div_val,
    output logic             clkg_q,
    output logic             rise_q,
    output logic             rise_d,
    output logic             bypass
);
    localparam int HW = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic             clkg;
        logic             rise;
        logic             run;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [HW-1:0] high_len;

    always_comb begin
        st_d     = st_q;
        high_len = '0;
        unique case (mode)
            MODE_DEVRST: begin
                st_d.cnt  = '0;
                st_d.div  = '0;
                st_d.run  = 1'b0;
                st_d.clkg = ~st_q.clkg;
                st_d.rise = ~st_q.clkg;
            end
            MODE_RUN: begin
                if (!st_q.run || st_q.cnt == st_q.div) begin
                    st_d.cnt = '0;
                    st_d.div = div_val;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
                st_d.run  = 1'b1;
                high_len  = ({1'b0, st_d.div} + HW'(1)) >> 1;
                st_d.clkg = ({1'b0, st_d.cnt} < high_len);
                st_d.rise = (st_d.cnt == '0);
            end
            default: begin
                st_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign clkg_q = st_q.clkg;
    assign rise_q = st_q.rise;
    assign rise_d = st_d.rise;
    assign bypass = st_q.run && (st_q.div == '0);

    AST_RST_TOGGLE: assert property (@(posedge clk)
        (mode == MODE_DEVRST) |=> (st_q.clkg != $past(st_q.clkg))); // R1

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (mode == MODE_DEVRST)
        (mode == MODE_IDLE) |=> (!st_q.clkg && !st_q.rise)); // R2

    AST_STROBE_HIGH: assert property (@(posedge clk) disable iff (mode == MODE_DEVRST)
        (st_q.rise && st_q.div != '0) |-> st_q.clkg); // R3

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (mode != MODE_RUN)
        (st_q.run && st_q.cnt != st_q.div) |=> (st_q.div == $past(st_q.div))); // R8
endmodule

// File: rtl/ckfs_frame.sv
module ckfs_frame
    import ckfs_pkg::*;
#(
    parameter int FRM_W = 8
) (
    input  logic             clk,
    input  ckfs_mode_e       mode,
    input  logic             frm_en,
    input  logic             tick,
    input  logic [FRM_W-1:0] per,
    input  logic [FRM_W-1:0] wid,
    output logic             fsg_q,
    output logic             fsg_rise_q
);
    typedef struct packed {
        logic [FRM_W-1:0] cnt;
        logic             first;
        logic             act;
        logic             fsg;
        logic             frise;
    } frm_st_t;

    frm_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.frise = 1'b0;
        if (mode != MODE_RUN || !frm_en) begin
            st_d.cnt   = '0;
            st_d.first = 1'b1;
            st_d.act   = 1'b0;
            st_d.fsg   = 1'b0;
        end else begin
            st_d.act = 1'b1;
            if (st_q.act && tick) begin
                if (st_q.cnt == per) begin
                    st_d.cnt   = '0;
                    st_d.first = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
                st_d.fsg = !st_d.first && (st_d.cnt <= wid);
            end
            st_d.frise = st_d.fsg && !st_q.fsg;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fsg_q      = st_q.fsg;
    assign fsg_rise_q = st_q.frise;

    AST_FRST_OFF: assert property (@(posedge clk) disable iff (mode == MODE_DEVRST)
        (!frm_en) |=> !st_q.fsg); // R7

    AST_FSG_RISE_HI: assert property (@(posedge clk) disable iff (mode == MODE_DEVRST)
        st_q.frise |-> (st_q.fsg && !$past(st_q.fsg))); // R10
endmodule

// File: rtl/ckfs_gen.sv
module ckfs_gen
    import ckfs_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int FRM_W = 8
) (
    input  logic             clk,
    input  logic             dev_rst,
    input  logic             gen_en,
    input  logic             frm_en,
    input  logic [DIV_W-1:0] div_val,
    input  logic [FRM_W-1:0] frm_per,
    input  logic [FRM_W-1:0] frm_wid,
    output logic             clkg,
    output logic             clkg_rise,
    output logic             fsg,
    output logic             fsg_rise
);
    ckfs_mode_e mode;
    logic       clkg_q;
    logic       rise_next;
    logic       bypass;

    always_comb begin
        if (dev_rst)     mode = MODE_DEVRST;
        else if (gen_en) mode = MODE_RUN;
        else             mode = MODE_IDLE;
    end

    ckfs_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .mode    (mode),
        .div_val (div_val),
        .clkg_q  (clkg_q),
        .rise_q  (clkg_rise),
        .rise_d  (rise_next),
        .bypass  (bypass)
    );

    ckfs_frame #(.FRM_W(FRM_W)) u_frm (
        .clk        (clk),
        .mode       (mode),
        .frm_en     (frm_en),
        .tick       (rise_next),
        .per        (frm_per),
        .wid        (frm_wid),
        .fsg_q      (fsg),
        .fsg_rise_q (fsg_rise)
    );

    assign clkg = bypass ? clk : clkg_q;

    AST_RST_FSG_LOW: assert property (@(posedge clk)
        dev_rst |=> (!fsg && !fsg_rise)); // R1

    AST_FSG_ON_CLKG: assert property (@(posedge clk) disable iff (dev_rst)
        $rose(fsg) |-> clkg_rise); // R5
endmodule

// File: tb/sim_ckfs_gen.sv
module sim_ckfs_gen;
    logic       clk = 1'b0;
    logic       dev_rst = 1'b1;
    logic       gen_en = 1'b0;
    logic       frm_en = 1'b0;
    logic [7:0] div_val = 8'd0;
    logic [7:0] frm_per = 8'd0;
    logic [7:0] frm_wid = 8'd0;
    logic       clkg, clkg_rise, fsg, fsg_rise;

    int n_chk = 0;
    int n_err = 0;
    int wd = 0;
    string clk_tag = "";

    // behavioural reference state
    bit m_clk = 0, m_rise = 0, m_run = 0, m_arm = 0, m_fsg = 0, m_frise = 0;
    int m_pos = 0, m_div = 0, m_k = 0;

    ckfs_gen u0 (
        .clk(clk), .dev_rst(dev_rst), .gen_en(gen_en), .frm_en(frm_en),
        .div_val(div_val), .frm_per(frm_per), .frm_wid(frm_wid),
        .clkg(clkg), .clkg_rise(clkg_rise), .fsg(fsg), .fsg_rise(fsg_rise)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit was_arm, prev_fsg;
        was_arm = m_arm;
        if (dev_rst) begin
            m_clk = !m_clk; m_rise = m_clk; m_run = 0; m_pos = 0; m_div = 0;
        end else if (!gen_en) begin
            m_clk = 0; m_rise = 0; m_run = 0; m_pos = 0; m_div = 0;
        end else begin
            if (!m_run || m_pos == m_div) begin
                m_pos = 0; m_div = int'(div_val);
            end else m_pos++;
            m_run  = 1;
            m_clk  = (m_pos < (m_div + 1) / 2);
            m_rise = (m_pos == 0);
        end
        m_arm = !dev_rst && gen_en && frm_en;
        prev_fsg = m_fsg;
        if (!m_arm) begin
            m_k = 0; m_fsg = 0;
        end else if (was_arm && m_rise) begin
            m_k++;
            m_fsg = (m_k >= int'(frm_per) + 1) && ((m_k % (int'(frm_per) + 1)) <= int'(frm_wid));
        end
        m_frise = m_fsg && !prev_fsg;
    end

    // bypass: the clock must be high just after each rising edge (R4)
    always @(posedge clk) begin
        #1;
        if (m_run && m_div == 0 && !dev_rst && gen_en) chk("R4", "clkg high phase", clkg, 1);
    end

    always @(negedge clk) begin
        string ct, ft;
        if (dev_rst) begin ct = "R1"; ft = "R1"; end
        else if (!gen_en) begin ct = "R2"; ft = "R2"; end
        else begin
            ct = (m_run && m_div == 0) ? "R4" : ((clk_tag != "") ? clk_tag : "R3");
            ft = "R6";
        end
        chk(ct, "clkg", clkg, (m_run && m_div == 0) ? 0 : int'(m_clk));
        chk(ct, "clkg_rise", clkg_rise, m_rise);
        chk(ft, "fsg", fsg, m_fsg);
        chk("R10", "fsg_rise", fsg_rise, m_frise);
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // arm the frame counter and check the exact cycle of the first pulse
    task automatic first_pulse(input string tag);
        int rises = 0;
        bit seen = 0;
        frm_en = 1'b1;
        @(negedge clk); // arming edge: its strobe is not counted
        for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk);
            if (clkg_rise) rises++;
            if (rises == int'(frm_per) + 1) begin
                chk(tag, "first fsg", fsg, 1);
                chk(tag, "first fsg_rise", fsg_rise, 1);
                seen = 1;
            end else chk(tag, "fsg before first pulse", fsg, 0);
        end
        chk(tag, "first pulse reached", seen, 1);
    endtask

    initial begin
        cyc(1);
        chk("R1", "fsg in device reset", fsg, 0);
        cyc(6);                                   // R1 divide-by-2 during device reset
        dev_rst = 1'b0;
        cyc(5);                                   // R2 software reset holds low
        chk("R2", "clkg idle", clkg, 0);
        chk("R2", "fsg idle", fsg, 0);

        div_val = 8'd3;
        gen_en = 1'b1;
        @(negedge clk);
        chk("R9", "clkg after enable", clkg, 1);
        chk("R9", "clkg_rise after enable", clkg_rise, 1);
        cyc(20);                                  // R3 even period

        clk_tag = "R8";
        @(negedge clk); @(negedge clk);
        div_val = 8'd2;                           // mid-period change
        cyc(20);
        div_val = 8'd5;
        cyc(3);
        div_val = 8'd4;
        cyc(20);
        clk_tag = "";

        frm_per = 8'd3; frm_wid = 8'd0;
        first_pulse("R5");
        cyc(60);                                  // R6 repeated pulses

        frm_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7", "fsg after frame disable", fsg, 0);
        frm_per = 8'd4; frm_wid = 8'd1;
        cyc(3);
        first_pulse("R7");
        cyc(80);                                  // R6 wider pulses

        div_val = 8'd0;
        cyc(30);                                  // R4 bypass with frames running
        div_val = 8'd1;
        cyc(20);

        gen_en = 1'b0;
        cyc(6);                                   // R2 with frame enable still set
        gen_en = 1'b1;
        cyc(40);
        dev_rst = 1'b1;
        cyc(6);                                   // R1 reset while running
        dev_rst = 1'b0;
        cyc(10);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule